// File: doc/BRIEF.md
# Zero-Turnaround Synchronous SRAM Core

This block is a synthesizable single-port memory with a zero-turnaround command interface and flow-through read data. Every rising clock edge that is not frozen samples one command: an address, a read/write select, a load/advance select, three chip-select inputs and one active-low write enable per byte lane. The data that goes with a write command arrives one edge later. Because of this lag, reads and writes can follow each other on consecutive cycles with no idle cycle between them. Read data for an address sampled at one edge appears combinationally in the cycle that follows it, with no output register.

A load command captures a new external address. An advance command steps a 2-bit burst counter inside a group of four words and repeats the operation type of the last load. A mode input selects a linear or an interleaved burst order. A high hold input makes an edge ignored: every register keeps its value. The shared data bus is split into a data input, a data output and an output drive enable.

Top module: `zt_sram`

## Requirements
- R1: While reset is high and in the first cycle after it, `dout_oe` is low. Reset empties the pipeline to a deselected state.
- R2: A load read (`adv`=0, `wr_n`=1) of address A sampled at edge k drives the stored word of A on `dout`, with `dout_oe` high, in the cycle after edge k.
- R3: Bit i of `lane_we_n` is sampled with the write command. When it is low, `din[8i+7:8i]` is written. When it is high, that byte of the addressed word keeps its old contents.
- R4: The write data for a write command sampled at edge k is taken from `din` at the next unfrozen edge. A read may be issued at that edge, even to the same address, and it returns the new data.
- R5: When `hold` is high at an edge, that edge is ignored. No register and no memory word changes, so `dout` and `dout_oe` stay as they were, and a pending write takes its data at the next edge where `hold` is low.
- R6: If `sel_n_a` is high, `sel_n_b` is high or `sel_p` is low at an edge, the command is a deselect. It performs no read and no write and does not move the burst counter.
- R7: After a deselect, `dout_oe` goes low in the cycle that follows it. A write issued just before the deselect still takes its data at the deselect edge.
- R8: `dout_oe` is high only while `out_en_n` is low, the last unfrozen edge accepted a selected read, and that edge did not accept a write.
- R9: With `order_mode`=0 (linear), the k-th advance after a load of address A accesses the word whose two low bits are (A[1:0]+k) mod 4. The upper address bits stay as loaded.
- R10: With `order_mode`=1 (interleaved), the k-th advance accesses the word whose two low bits are A[1:0] xor k. The upper address bits stay as loaded.
- R11: An advance repeats the operation type of the last selected command and ignores `wr_n`. A burst write takes one data word per edge, one edge after each address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| hold | input | 1 | High: the current edge is ignored |
| sel_n_a | input | 1 | Active-low chip select |
| sel_n_b | input | 1 | Active-low chip select |
| sel_p | input | 1 | Active-high chip select |
| adv | input | 1 | 0: load a new address, 1: advance the burst |
| wr_n | input | 1 | On a load, 0 is a write and 1 is a read |
| addr | input | ADDR_W | Word address |
| lane_we_n | input | LANES | Active-low byte-lane write enables |
| order_mode | input | 1 | Burst order: 0 linear, 1 interleaved |
| out_en_n | input | 1 | Active-low output enable |
| din | input | 8*LANES | Write data, one edge after its command |
| dout | output | 8*LANES | Flow-through read data |
| dout_oe | output | 1 | Output drive enable for `dout` |

## Verification
The internal state here is the command stage, the last-operation flag and the burst base and count. If the stage address or the counter is wrong, `dout` shows the wrong word in the same cycle as the bad access, because reads go straight to the output. That is why every read in the sweeps is compared in the cycle right after its command. If the last-operation flag or the stage op is wrong, it shows as a bad `dout_oe`, or as a missing or stray write that a later read-back exposes. If a frozen edge leaks through, the state moves one word ahead. That shows up in the next flow-through read and in the data a delayed write stores.

// File: rtl/zt_sram_pkg.sv
package zt_sram_pkg;

    localparam int LANE_W = 8;

    typedef enum logic {
        OP_READ  = 1'b0,
        OP_WRITE = 1'b1
    } op_e;

    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } order_e;

    // slot within a four-word group for the given step of a burst
    function automatic logic [1:0] burst_slot(input logic [1:0] start,
                                              input logic [1:0] step,
                                              input order_e     mode);
        logic [1:0] r;
        if (mode == ORD_INTERLEAVE) r = start ^ step;
        else                        r = start + step;
        return r;
    endfunction

endpackage

// File: rtl/zt_sram_burst.sv
module zt_sram_burst
    import zt_sram_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              load,
    input  logic              step,
    input  logic [ADDR_W-1:0] ext_addr,
    input  order_e            mode,
    output logic [ADDR_W-1:0] cur_addr
);
    localparam int HI_W = ADDR_W - 2;

    logic [ADDR_W-1:0] base_q;
    logic [1:0]        cnt_q;
    logic [1:0]        cnt_nx;

    assign cnt_nx = cnt_q + 2'd1;

    always_comb begin
        if (load) cur_addr = ext_addr;
        else      cur_addr = {base_q[ADDR_W-1 -: HI_W], burst_slot(base_q[1:0], cnt_nx, mode)};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            cnt_q  <= 2'd0;
        end else if (tick) begin
            if (load) begin
                base_q <= ext_addr;
                cnt_q  <= 2'd0;
            end else if (step) begin
                cnt_q  <= cnt_nx;
            end
        end
    end

endmodule

// File: rtl/zt_sram_array.sv
module zt_sram_array
    import zt_sram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4
) (
    input  logic                     clk,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [LANES-1:0]         lane_en,
    input  logic [LANES*LANE_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0]        rd_addr,
    output logic [LANES*LANE_W-1:0]  rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] cells [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_en && lane_en[g]) cells[wr_addr] <= wr_data[g*LANE_W +: LANE_W];
        end

        assign rd_data[g*LANE_W +: LANE_W] = cells[rd_addr];
    end

endmodule

// File: rtl/zt_sram.sv
module zt_sram
    import zt_sram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int DATA_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hold,
    input  logic              sel_n_a,
    input  logic              sel_n_b,
    input  logic              sel_p,
    input  logic              adv,
    input  logic              wr_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LANES-1:0]  lane_we_n,
    input  logic              order_mode,
    input  logic              out_en_n,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dout_oe
);
    typedef struct packed {
        logic              valid;
        op_e               op;
        logic [ADDR_W-1:0] addr;
        logic [LANES-1:0]  lane_en;
    } stage_t;

    stage_t            stage_q;
    op_e               last_op_q;
    op_e               cmd_op;
    logic              tick;
    logic              selected;
    logic [ADDR_W-1:0] gen_addr;
    logic              wr_en;
    order_e            mode;

    assign tick     = !hold;
    assign selected = !sel_n_a && !sel_n_b && sel_p;
    assign mode     = order_e'(order_mode);

    always_comb begin
        if (adv)       cmd_op = last_op_q;
        else if (wr_n) cmd_op = OP_READ;
        else           cmd_op = OP_WRITE;
    end

    zt_sram_burst #(.ADDR_W(ADDR_W)) u_burst (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .load     (selected && !adv),
        .step     (selected && adv),
        .ext_addr (addr),
        .mode     (mode),
        .cur_addr (gen_addr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q   <= '0;
            last_op_q <= OP_READ;
        end else if (tick) begin
            stage_q.valid   <= selected;
            stage_q.op      <= cmd_op;
            stage_q.addr    <= gen_addr;
            stage_q.lane_en <= ~lane_we_n;
            if (selected) last_op_q <= cmd_op;
        end
    end

    assign wr_en = tick && stage_q.valid && (stage_q.op == OP_WRITE);

    zt_sram_array #(.ADDR_W(ADDR_W), .LANES(LANES)) u_array (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (stage_q.addr),
        .lane_en (stage_q.lane_en),
        .wr_data (din),
        .rd_addr (stage_q.addr),
        .rd_data (dout)
    );

    assign dout_oe = stage_q.valid && (stage_q.op == OP_READ) && !out_en_n;

endmodule

// File: rtl/zt_sram_chk.sv
module zt_sram_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              hold,
    input logic              sel_n_a,
    input logic              sel_n_b,
    input logic              sel_p,
    input logic              adv,
    input logic              wr_n,
    input logic              out_en_n,
    input logic [DATA_W-1:0] dout,
    input logic              dout_oe
);
    logic desel;
    assign desel = sel_n_a || sel_n_b || !sel_p;

    assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !dout_oe);

    assert_hold_freeze_R5: assert property (@(posedge clk) disable iff (rst)
        hold |=> $stable(dout));

    assert_low_select_R6: assert property (@(posedge clk) disable iff (rst)
        $past(!hold && !sel_p) |-> !dout_oe);

    assert_deselect_off_R7: assert property (@(posedge clk) disable iff (rst)
        $past(!hold && desel) |-> !dout_oe);

    assert_write_no_drive_R8: assert property (@(posedge clk) disable iff (rst)
        $past(!hold && !desel && !adv && !wr_n) |-> !dout_oe);

    assert_oe_gate_R8: assert property (@(posedge clk) disable iff (rst)
        out_en_n |-> !dout_oe);

endmodule

bind zt_sram zt_sram_chk #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .hold     (hold),
    .sel_n_a  (sel_n_a),
    .sel_n_b  (sel_n_b),
    .sel_p    (sel_p),
    .adv      (adv),
    .wr_n     (wr_n),
    .out_en_n (out_en_n),
    .dout     (dout),
    .dout_oe  (dout_oe)
);

// File: tb/zt_sram_test.sv
module zt_sram_test;
    localparam int AW = 6;
    localparam int LN = 4;
    localparam int DW = LN * 8;
    localparam int NW = 1 << AW;

    logic          clk = 0;
    logic          rst = 1;
    logic          hold = 0;
    logic          sel_n_a = 1, sel_n_b = 0, sel_p = 1;
    logic          adv = 0, wr_n = 1;
    logic [AW-1:0] addr = '0;
    logic [LN-1:0] lane_we_n = '1;
    logic          order_mode = 0;
    logic          out_en_n = 0;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout;
    logic          dout_oe;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [DW-1:0] shadow [NW];

    zt_sram #(.ADDR_W(AW), .LANES(LN)) uut (
        .clk(clk), .rst(rst), .hold(hold), .sel_n_a(sel_n_a), .sel_n_b(sel_n_b),
        .sel_p(sel_p), .adv(adv), .wr_n(wr_n), .addr(addr), .lane_we_n(lane_we_n),
        .order_mode(order_mode), .out_en_n(out_en_n), .din(din), .dout(dout),
        .dout_oe(dout_oe)
    );

    always #2 clk = ~clk;

    function automatic logic [DW-1:0] pat(input int a, input int salt);
        return DW'(a * 32'h01030507 + salt * 32'h9E3779B1 + 32'h5A);
    endfunction

    function automatic logic [DW-1:0] merge(input logic [DW-1:0] old, input logic [DW-1:0] nw,
                                           input logic [LN-1:0] we_n);
        logic [DW-1:0] r = old;
        for (int i = 0; i < LN; i++) if (!we_n[i]) r[i*8 +: 8] = nw[i*8 +: 8];
        return r;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic edge_();
        @(posedge clk);
        #1;
    endtask

    // one selected command; d is the write data for the previous command
    task automatic cmd(input logic w_n, input logic a_adv, input int a,
                       input logic [LN-1:0] we_n, input logic [DW-1:0] d);
        sel_n_a = 0; sel_n_b = 0; sel_p = 1;
        wr_n = w_n; adv = a_adv; addr = AW'(a); lane_we_n = we_n; din = d;
        edge_();
    endtask

    task automatic desel(input logic [DW-1:0] d);
        sel_n_a = 1; adv = 0; wr_n = 1; din = d;
        edge_();
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] v;
        repeat (3) edge_();
        chk(dout_oe == 0, "R1 oe in reset", DW'(dout_oe), 0);
        rst = 0;
        desel('0);
        chk(dout_oe == 0, "R1 oe after reset", DW'(dout_oe), 0);

        // R2: fill every word back to back, then read every word back to back
        for (int a = 0; a < NW; a++) begin
            cmd(0, 0, a, '0, (a == 0) ? '0 : pat(a - 1, 0));
            shadow[a] = pat(a, 0);
        end
        desel(pat(NW - 1, 0));
        for (int a = NW - 1; a >= 0; a--) begin
            cmd(1, 0, a, '1, '0);
            chk(dout == shadow[a] && dout_oe, "R2 read", dout, shadow[a]);
        end

        // R4: write then read of the same word on the next edge, alternating
        for (int a = 0; a < 16; a++) begin
            cmd(0, 0, a, '0, '0);
            cmd(1, 0, a, '1, pat(a, 1));
            shadow[a] = pat(a, 1);
            chk(dout == shadow[a] && dout_oe, "R4 write-read turnaround", dout, shadow[a]);
        end

        // R3: every lane mask on one word
        for (int m = 0; m < 16; m++) begin
            cmd(0, 0, 20, LN'(m), '0);
            cmd(1, 0, 20, '1, pat(m, 2));
            shadow[20] = merge(shadow[20], pat(m, 2), LN'(m));
            chk(dout == shadow[20], "R3 lane mask", dout, shadow[20]);
        end

        // R5: frozen edges between write command and its data
        cmd(0, 0, 30, '0, '0);
        hold = 1;
        din = 32'hDEAD_BEEF; addr = 31; wr_n = 1;
        edge_(); edge_();
        hold = 0;
        cmd(1, 0, 30, '1, pat(30, 3));
        shadow[30] = pat(30, 3);
        chk(dout == shadow[30], "R5 pending write after hold", dout, shadow[30]);
        cmd(1, 0, 31, '1, '0);
        v = dout;
        hold = 1; addr = 7; wr_n = 0; adv = 0;
        edge_(); edge_();
        chk(dout == v && dout_oe, "R5 read frozen", dout, v);
        hold = 0;
        chk(v == shadow[31], "R5 held read data", v, shadow[31]);

        // R6: each chip select alone makes a deselect
        for (int k = 0; k < 3; k++) begin
            sel_n_a = (k == 0); sel_n_b = (k == 1); sel_p = (k != 2);
            wr_n = 0; adv = 0; addr = AW'(40 + k); lane_we_n = '0; din = '0;
            edge_();
            chk(dout_oe == 0, "R6 deselect no drive", DW'(dout_oe), 0);
            cmd(1, 0, 40 + k, '1, 32'hBAD0_0000);
            chk(dout == shadow[40 + k], "R6 deselected write ignored", dout, shadow[40 + k]);
        end

        // R7: drive stops one cycle after deselect; pending write completes
        cmd(1, 0, 5, '1, '0);
        chk(dout_oe == 1, "R7 read drives", DW'(dout_oe), 1);
        desel('0);
        chk(dout_oe == 0, "R7 drive off after deselect", DW'(dout_oe), 0);
        cmd(0, 0, 6, '0, '0);
        desel(pat(6, 4));
        shadow[6] = pat(6, 4);
        cmd(1, 0, 6, '1, '0);
        chk(dout == shadow[6], "R7 write finishes over deselect", dout, shadow[6]);

        // R8: output enable gating
        out_en_n = 1;
        cmd(1, 0, 9, '1, '0);
        chk(dout_oe == 0 && dout == shadow[9], "R8 oe off when disabled", DW'(dout_oe), 0);
        out_en_n = 0; #0.5;
        chk(dout_oe == 1, "R8 oe on when enabled", DW'(dout_oe), 1);
        cmd(0, 0, 10, '1, '0);
        chk(dout_oe == 0, "R8 no drive on write", DW'(dout_oe), 0);
        desel('0);

        // R9 / R10: read bursts, every start slot, both orders
        for (int md = 0; md < 2; md++) begin
            order_mode = md[0];
            for (int s = 0; s < 4; s++) begin
                cmd(1, 0, 32 + s, '1, '0);
                for (int j = 1; j < 4; j++) begin
                    int e;
                    e = 32 + (md ? (s ^ j) : ((s + j) % 4));
                    cmd(0, 1, 0, '1, '0);
                    chk(dout == shadow[e] && dout_oe,
                        md ? "R10 interleaved burst read" : "R9 linear burst read",
                        dout, shadow[e]);
                end
            end
        end

        // R11: burst writes, advance repeats write and ignores wr_n
        for (int md = 0; md < 2; md++) begin
            int g, s;
            logic [DW-1:0] prev;
            g = md ? 52 : 48; s = md ? 2 : 1;
            order_mode = md[0];
            cmd(0, 0, g + s, '0, '0);
            prev = pat(g + s, 5);
            shadow[g + s] = prev;
            for (int j = 1; j < 4; j++) begin
                int e;
                e = g + (md ? (s ^ j) : ((s + j) % 4));
                cmd(1, 1, 0, '0, prev);
                prev = pat(e, 5);
                shadow[e] = prev;
            end
            desel(prev);
            for (int w = 0; w < 4; w++) begin
                cmd(1, 0, g + w, '1, '0);
                chk(dout == shadow[g + w], "R11 burst write stored", dout, shadow[g + w]);
            end
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule